// File: doc/BRIEF.md
# Per-Context Event Priority Selector

This block serves a hardware task scheduler that runs several execution contexts. Each context owns three registers: a pending-event word, an enable word and a priority word. Every clock cycle the block looks at the events that are both pending and enabled in each context. It then picks the one category that context should service next. The result goes into a 3-bit current-event register for that context. A per-context flag tells the scheduler that the context has work to do.

Seven event categories are tracked per context:

| Bit | Category |
|-----|----------|
| 0 | timer |
| 1 | watchdog |
| 2 | first deadline |
| 3 | second deadline |
| 4 | interrupt |
| 5 | mutex |
| 6 | message synchronization |

Each context gives each category its own programmable 3-bit priority, so the ranking can differ from one context to the next. External interrupt lines keep one fixed global order. Each line is routed to a context of choice, where it raises that context's interrupt category. A global register reports the number of the most urgent active line.

Event sources pulse `evt_set`. The scheduler or software removes serviced events through a write-one-to-clear port. The enable and priority words are written through a small configuration port, and may be rewritten at any time.

Top module: `evt_prio_sel`

## Requirements
- R1: A high bit k in a context's slice of `evt_set` sets bit k of that context's pending word. Bit k is category k, numbered as in the table above. When that bit is enabled, `evt_pend` for the context is high from the cycle after the setting edge.
- R2: A pending bit whose enable bit is clear has no effect. It does not raise `evt_pend` and it is never selected.
- R3: Category k's priority sits in bits [3k+2:3k] of the priority word, and a smaller value is more urgent. `cur_evt` shows the index of the most urgent enabled pending category. It is registered, so it reflects the register state one clock later.
- R4: When two enabled pending categories have the same priority value, the lower category index is selected.
- R5: When a context has no enabled pending category, its `cur_evt` reads 7.
- R6: A `clr_we` pulse clears the pending bits of `clr_ctx` selected by ones in `clr_mask`. If a set and a clear hit the same bit in the same cycle, the set wins.
- R7: `irq_top` is registered and holds the lowest-numbered active line in `irq_lines`, since line 0 is the most urgent. `irq_any` is registered and is high when any line is active. With no line active, both read 0.
- R8: Line l is routed to the context given by `irq_route[l*CW +: CW]`. While the line is high, it sets bit 4 of that context's pending word every cycle, so clearing that bit does not take while the line stays high.
- R9: A priority word rewritten at run time steers the selection from the next cycle on.
- R10: After reset, every pending, enable and priority word is 0, every `cur_evt` reads 7, and `evt_pend` and `irq_any` are low.
- R11: Priority bits 31..21 and enable bits 31..7 written through `cfg_data` are dropped and have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| evt_set | input | NCTX*7 | per-context event set pulses, 7 bits per context |
| clr_we | input | 1 | clear strobe |
| clr_ctx | input | CW | context to clear |
| clr_mask | input | 7 | categories to clear, one bit each |
| cfg_we | input | 1 | configuration write strobe |
| cfg_pri | input | 1 | 1 writes the priority word, 0 writes the enable word |
| cfg_ctx | input | CW | context written |
| cfg_data | input | 32 | configuration data |
| irq_lines | input | NIRQ | external interrupt levels |
| irq_route | input | NIRQ*CW | target context for each line |
| cur_evt | output | NCTX*3 | current event per context, 7 = none |
| evt_pend | output | NCTX | context has an enabled pending event |
| irq_top | output | IW | number of the most urgent active line |
| irq_any | output | 1 | some line is active |

## Verification
Several properties are checked on every cycle:
- `cur_evt` goes idle one cycle after a context has nothing to service, and leaves idle one cycle after it has something.
- The selected category was enabled and pending in the previous cycle.
- A full clear with no competing set empties the context.
- The reported interrupt line was really active, and `irq_any` drops when no line is active.

Other behaviours need the bench's scenarios, because they depend on comparing priority values:
- the choice by priority value, and the tie rule;
- the effect of a run-time priority rewrite;
- set winning over clear;
- the re-raising of a routed interrupt while its line is held;
- the dropping of unused configuration bits.

// File: rtl/evt_prio_sel.sv
module evt_prio_sel #(
  parameter int NCTX = 4,
  parameter int NIRQ = 8,
  localparam int CW = (NCTX > 1) ? $clog2(NCTX) : 1,
  localparam int IW = (NIRQ > 1) ? $clog2(NIRQ) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCTX*7-1:0] evt_set,
  input  logic              clr_we,
  input  logic [CW-1:0]     clr_ctx,
  input  logic [6:0]        clr_mask,
  input  logic              cfg_we,
  input  logic              cfg_pri,
  input  logic [CW-1:0]     cfg_ctx,
  input  logic [31:0]       cfg_data,
  input  logic [NIRQ-1:0]   irq_lines,
  input  logic [NIRQ*CW-1:0] irq_route,
  output logic [NCTX*3-1:0] cur_evt,
  output logic [NCTX-1:0]   evt_pend,
  output logic [IW-1:0]     irq_top,
  output logic              irq_any
);

  localparam logic [2:0] IDLE = 3'd7;

  logic [6:0]      pend_q [NCTX];
  logic [6:0]      en_q   [NCTX];
  logic [20:0]     pri_q  [NCTX];
  logic [2:0]      cur_q  [NCTX];
  logic [NCTX-1:0] irq_hit;
  logic [IW-1:0]   top_d;

  function automatic logic [2:0] pick(input logic [6:0] act, input logic [20:0] pri);
    logic       found;
    logic [2:0] bp;
    logic [2:0] sel;
    found = 1'b0;
    bp    = 3'd0;
    sel   = IDLE;
    for (int k = 0; k < 7; k++) begin
      if (act[k] && (!found || pri[3*k +: 3] < bp)) begin
        found = 1'b1;
        bp    = pri[3*k +: 3];
        sel   = 3'(k);
      end
    end
    return sel;
  endfunction

  always_comb begin
    irq_hit = '0;
    for (int l = 0; l < NIRQ; l++)
      if (irq_lines[l]) irq_hit[irq_route[l*CW +: CW]] = 1'b1;
  end

  always_comb begin
    top_d = '0;
    for (int l = NIRQ - 1; l >= 0; l--)
      if (irq_lines[l]) top_d = IW'(l);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_top <= '0;
      irq_any <= 1'b0;
    end else begin
      irq_top <= top_d;
      irq_any <= |irq_lines;
    end
  end

  for (genvar c = 0; c < NCTX; c++) begin : g_ctx
    logic [6:0] clr_c, set_c;
    assign clr_c = (clr_we && clr_ctx == CW'(c)) ? clr_mask : 7'd0;
    assign set_c = evt_set[c*7 +: 7] | {2'b00, irq_hit[c], 4'b0000};

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pend_q[c] <= '0;
        en_q[c]   <= '0;
        pri_q[c]  <= '0;
        cur_q[c]  <= IDLE;
      end else begin
        pend_q[c] <= (pend_q[c] & ~clr_c) | set_c;
        if (cfg_we && cfg_ctx == CW'(c)) begin
          if (cfg_pri) pri_q[c] <= cfg_data[20:0];
          else         en_q[c]  <= cfg_data[6:0];
        end
        cur_q[c] <= pick(pend_q[c] & en_q[c], pri_q[c]);
      end
    end

    assign evt_pend[c]        = |(pend_q[c] & en_q[c]);
    assign cur_evt[c*3 +: 3]  = cur_q[c];

    p_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !evt_pend[c] |=> cur_evt[c*3 +: 3] == IDLE);

    p_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
      evt_pend[c] |=> cur_evt[c*3 +: 3] != IDLE);

    p_pick_enabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cur_q[c] != IDLE |-> ((($past(pend_q[c] & en_q[c])) >> cur_q[c]) & 7'd1) != 7'd0);

    p_full_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_c == 7'h7f && evt_set[c*7 +: 7] == 7'd0 && !irq_hit[c]) |=> !evt_pend[c]);
  end

  p_irq_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_lines == '0 |=> !irq_any);

  p_irq_real_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_any |-> (($past(irq_lines) >> irq_top) & NIRQ'(1)) != '0);

endmodule

// File: tb/evt_prio_sel_tb.sv
module evt_prio_sel_tb;
  localparam int NCTX = 4;
  localparam int NIRQ = 8;
  localparam int CW = 2;
  localparam int IW = 3;

  logic clk = 0, rst_n = 0;
  logic [NCTX*7-1:0] evt_set = '0;
  logic clr_we = 0;
  logic [CW-1:0] clr_ctx = '0;
  logic [6:0] clr_mask = '0;
  logic cfg_we = 0, cfg_pri = 0;
  logic [CW-1:0] cfg_ctx = '0;
  logic [31:0] cfg_data = '0;
  logic [NIRQ-1:0] irq_lines = '0;
  logic [NIRQ*CW-1:0] irq_route;
  logic [NCTX*3-1:0] cur_evt;
  logic [NCTX-1:0] evt_pend;
  logic [IW-1:0] irq_top;
  logic irq_any;

  always #2 clk = ~clk;

  evt_prio_sel #(.NCTX(NCTX), .NIRQ(NIRQ)) u_dut (
    .clk(clk), .rst_n(rst_n), .evt_set(evt_set), .clr_we(clr_we), .clr_ctx(clr_ctx),
    .clr_mask(clr_mask), .cfg_we(cfg_we), .cfg_pri(cfg_pri), .cfg_ctx(cfg_ctx),
    .cfg_data(cfg_data), .irq_lines(irq_lines), .irq_route(irq_route),
    .cur_evt(cur_evt), .evt_pend(evt_pend), .irq_top(irq_top), .irq_any(irq_any));

  typedef struct { int kind; int ctx; int exp; string tag; } item_t;
  item_t q[$];
  int checks = 0, fails = 0;
  bit done = 0;

  initial for (int l = 0; l < NIRQ; l++) irq_route[l*CW +: CW] = CW'(l % NCTX);

  always begin
    @(negedge clk); #1;
    while (q.size() > 0) begin
      item_t it;
      int act;
      it = q.pop_front();
      case (it.kind)
        0: act = int'(cur_evt[it.ctx*3 +: 3]);
        1: act = int'(evt_pend[it.ctx]);
        2: act = int'(irq_top);
        default: act = int'(irq_any);
      endcase
      checks++;
      if (act != it.exp) begin
        fails++;
        $display("FAIL %s kind=%0d ctx=%0d actual=%0d expected=%0d", it.tag, it.kind, it.ctx, act, it.exp);
      end
    end
  end

  task automatic expect_v(input int kind, input int ctx, input int exp, input string tag);
    item_t it;
    it.kind = kind; it.ctx = ctx; it.exp = exp; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int ctx, input bit pri, input logic [31:0] d);
    cfg_we = 1; cfg_pri = pri; cfg_ctx = CW'(ctx); cfg_data = d;
    tick(1);
    cfg_we = 0;
  endtask

  task automatic setp(input int ctx, input logic [6:0] m);
    evt_set[ctx*7 +: 7] = m;
    tick(1);
    evt_set = '0;
  endtask

  task automatic clrp(input int ctx, input logic [6:0] m);
    clr_we = 1; clr_ctx = CW'(ctx); clr_mask = m;
    tick(1);
    clr_we = 0;
  endtask

  initial begin
    #800000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1;
    tick(1);
    for (int c = 0; c < NCTX; c++) begin
      expect_v(0, c, 7, "R10 cur idle");
      expect_v(1, c, 0, "R10 pend low");
    end
    expect_v(3, 0, 0, "R10 irq_any low");
    tick(1);

    // ctx0: timer=1, interrupt=0, msg=2, rest 7
    wr(0, 0, 32'h51);
    wr(0, 1, 32'h1 | (7<<3) | (7<<6) | (7<<9) | (0<<12) | (7<<15) | (2<<18));
    setp(0, 7'h40);
    expect_v(1, 0, 1, "R1 msg sets pending");
    tick(1);
    expect_v(0, 0, 6, "R3 msg selected");
    setp(0, 7'h01);
    tick(1);
    expect_v(0, 0, 0, "R3 timer beats msg by priority");

    // ctx1: pending but not enabled
    setp(1, 7'h04);
    expect_v(1, 1, 0, "R2 disabled pend ignored");
    tick(1);
    expect_v(0, 1, 7, "R2 disabled not selected");
    wr(1, 0, 32'h04);
    expect_v(1, 1, 1, "R2 enable exposes pend");
    tick(1);
    expect_v(0, 1, 2, "R2 now selected");

    // ctx2: unused enable bits dropped
    wr(2, 0, 32'hFFFF_FF80);
    setp(2, 7'h08);
    expect_v(1, 2, 0, "R11 high enable bits ignored");
    tick(1);
    expect_v(0, 2, 7, "R11 nothing selected");

    // ctx3: tie, with high priority bits ignored
    wr(3, 0, 32'h7F);
    wr(3, 1, 32'hFFE0_0000);
    setp(3, 7'h28);
    tick(1);
    expect_v(0, 3, 3, "R4 tie lower index / R11");
    wr(3, 1, 32'h7 << 9);
    tick(1);
    expect_v(0, 3, 5, "R9 rewrite priority");
    clrp(3, 7'h20);
    tick(1);
    expect_v(0, 3, 3, "R6 clear selected");
    clrp(3, 7'h08);
    expect_v(1, 3, 0, "R6 clear empties");
    tick(1);
    expect_v(0, 3, 7, "R5 idle code");
    evt_set[3*7 +: 7] = 7'h02;
    clr_we = 1; clr_ctx = 2'd3; clr_mask = 7'h02;
    tick(1);
    evt_set = '0; clr_we = 0;
    expect_v(1, 3, 1, "R6 set wins over clear");
    tick(1);
    expect_v(0, 3, 1, "R6 set wins selection");

    // ctx1: routed interrupt line 5
    wr(1, 0, 32'h14);
    wr(1, 1, 32'h3 << 6);
    tick(1);
    expect_v(0, 1, 2, "R9 deadline still selected");
    irq_lines = 8'h20;
    tick(1);
    expect_v(2, 0, 5, "R7 top line 5");
    expect_v(3, 0, 1, "R7 any high");
    tick(1);
    expect_v(0, 1, 4, "R8 routed irq selected");
    clrp(1, 7'h10);
    tick(1);
    expect_v(0, 1, 4, "R8 held line re-raises");
    irq_lines = '0;
    clrp(1, 7'h10);
    expect_v(3, 0, 0, "R7 any low");
    tick(1);
    expect_v(0, 1, 2, "R8 released and cleared");

    // interrupt encoder only
    irq_lines = 8'b1010_0100;
    tick(1);
    expect_v(2, 0, 2, "R7 lowest active wins");
    irq_lines = 8'h01;
    tick(1);
    expect_v(2, 0, 0, "R7 line 0");
    irq_lines = '0;
    tick(1);
    expect_v(2, 0, 0, "R7 none top zero");
    tick(2);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule